// File: doc/BRIEF.md
# Strobe-Driven FIFO with Retransmit

This block is a first-in/first-out buffer for 9-bit words, run from one system clock but controlled by active-low write and read strobes in the style of an asynchronous buffer. The clock samples each strobe, and the block acts on the strobe's edges. A falling write strobe stores the input word. A falling read strobe fetches the oldest word and presents it on the output bus for as long as the strobe stays low. Three active-low status flags report empty, more-than-half-full and full. Each flag changes on a chosen strobe edge, not at once from the fill level.

An active-low retransmit pulse rewinds the read pointer to storage location zero and leaves the write pointer where it is. The words written since the last reset can then be read again. After a rewind all three flags are recomputed from the new fill level. The output bus comes with an enable that models a three-state driver: the data is driven only while an accepted read strobe is held low, and the bus reads zero otherwise. Depth is a power-of-two parameter and can be set to 32768 words.

Top module: `strobe_fifo`

## Requirements
- R1: While `rstN` is low, both pointers return to location zero. Afterwards `emptyN`=0, `halfN`=1, `fullN`=1 and `qOe`=0, and the first word written after reset is the first word read.
- R2: Strobes are sampled on the rising clock edge. The effect of an edge takes place on the second rising edge after the input changes. For example, `qOe` rises two clock edges after `rdN` is driven low, and not after one.
- R3: Words come out in the order they were written.
- R4: An accepted write leaves `emptyN` unchanged at the falling edge of `wrN`. The flag goes high at the following rising edge of `wrN`.
- R5: `emptyN` goes low at the falling read edge that removes the last stored word. A read strobe that falls while `emptyN` is low is ignored: no word is removed and `qOe` stays 0.
- R6: `fullN` goes low at the falling write edge that fills the last free location. A write strobe that falls while `fullN` is low is ignored, and the word is not stored. `fullN` returns high on the rising edge of the next accepted read.
- R7: `halfN` goes low at the falling write edge that takes occupancy above DEPTH/2. It goes high again only on the rising edge of a read after which occupancy is at most DEPTH/2.
- R8: A falling edge on `rtN` while both `wrN` and `rdN` are high sets the read pointer to zero and keeps the write pointer. Occupancy becomes the write pointer, or DEPTH if the write pointer has wrapped back to zero. The flags follow from that occupancy.
- R9: A falling edge on `rtN` while either strobe is low is ignored.
- R10: `qOe` is 1 only from an accepted read's falling edge to its rising edge. `qOut` carries the read word while `qOe` is 1 and all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| rtN | input | 1 | Retransmit pulse, active low |
| dIn | input | 9 | Write data |
| qOut | output | 9 | Read data, zero while not enabled |
| qOe | output | 1 | Output-bus enable |
| emptyN | output | 1 | Empty flag, active low |
| halfN | output | 1 | Over-half-full flag, active low |
| fullN | output | 1 | Full flag, active low |

## Verification
The assertions assume that each strobe level lasts at least two clock cycles, so that both sampling registers see every edge. They also assume that write data stays steady while `wrN` is low. The flag properties further rely on a write and a read edge never arriving in the same cycle, so that a flag's set event and release event cannot collide. The stimulus meets all of these assumptions: every strobe phase is held for exactly two cycles, data changes only together with the falling edge of its strobe, and the vectors run one operation at a time. The one operation that overlaps a strobe with a retransmit pulse is the deliberate check that the pulse is rejected.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // One-cycle commands from the control to the datapath
  typedef struct packed {
    logic push;    // store dIn at the write pointer
    logic pop;     // fetch the word at the read pointer
    logic rewind;  // move the read pointer back to location zero
  } fifoCmd_t;
endpackage

// File: rtl/strobe_sync.sv
// Two-register sampler: the current and previous sampled level of an active-low strobe
module strobe_sync (
  input  logic clk,
  input  logic rstN,
  input  logic strobeN,
  output logic lvlNow,
  output logic lvlPrev
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlNow  <= 1'b1;
      lvlPrev <= 1'b1;
    end else begin
      lvlNow  <= strobeN;
      lvlPrev <= lvlNow;
    end
  end
endmodule

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] dIn,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              wrapped,
  output logic [DATA_W-1:0] qData
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= dIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrapped <= 1'b0;
    end else if (cmd.push) begin
      wrPtr <= wrPtr + 1'b1;
      if (wrPtr == LAST) wrapped <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      qData <= '0;
    end else if (cmd.rewind) begin
      rdPtr <= '0;
    end else if (cmd.pop) begin
      qData <= mem[rdPtr];
      rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrNow,
  input  logic              wrPrev,
  input  logic              rdNow,
  input  logic              rdPrev,
  input  logic              rtNow,
  input  logic              rtPrev,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic              wrapped,
  output fifoCmd_t          cmd,
  output logic [CNT_W-1:0]  occ,
  output logic              emptyN,
  output logic              halfN,
  output logic              fullN,
  output logic              rdActive
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic wrFall, wrRise, rdFall, rdRise, rtFall, bothIdle;
  logic pushOk, popOk, rewindOk, wrPend;
  logic [CNT_W-1:0] occNext;

  assign wrFall   = wrPrev & ~wrNow;
  assign wrRise   = ~wrPrev & wrNow;
  assign rdFall   = rdPrev & ~rdNow;
  assign rdRise   = ~rdPrev & rdNow;
  assign rtFall   = rtPrev & ~rtNow;
  assign bothIdle = wrNow & wrPrev & rdNow & rdPrev;

  assign pushOk   = wrFall & fullN;
  assign popOk    = rdFall & emptyN;
  assign rewindOk = rtFall & bothIdle;

  assign cmd = '{push: pushOk, pop: popOk, rewind: rewindOk};

  always_comb begin
    if (rewindOk)
      occNext = (wrPtr == '0 && wrapped) ? FULL_CNT : {1'b0, wrPtr};
    else
      occNext = occ + CNT_W'(pushOk) - CNT_W'(popOk);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ      <= '0;
      emptyN   <= 1'b0;
      halfN    <= 1'b1;
      fullN    <= 1'b1;
      wrPend   <= 1'b0;
      rdActive <= 1'b0;
    end else begin
      occ <= occNext;

      // empty: set by the read that drains, released by a write's rising edge
      if (rewindOk)                emptyN <= (occNext != '0);
      else if (popOk && occNext == '0) emptyN <= 1'b0;
      else if (wrRise && wrPend)   emptyN <= (occNext != '0);

      // full: set by the write that fills, released by a read's rising edge
      if (rewindOk)                fullN <= (occNext != FULL_CNT);
      else if (pushOk && occNext == FULL_CNT) fullN <= 1'b0;
      else if (rdRise && rdActive) fullN <= (occNext != FULL_CNT);

      // half: set on a write's falling edge, released on a read's rising edge
      if (rewindOk)                halfN <= !(occNext > HALF_CNT);
      else if (pushOk && occNext > HALF_CNT) halfN <= 1'b0;
      else if (rdRise && rdActive) halfN <= !(occNext > HALF_CNT);

      if (rewindOk || wrRise) wrPend <= 1'b0;
      else if (pushOk)        wrPend <= 1'b1;

      if (rewindOk || rdRise) rdActive <= 1'b0;
      else if (popOk)         rdActive <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int N_STB  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              rtN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qOut,
  output logic              qOe,
  output logic              emptyN,
  output logic              halfN,
  output logic              fullN
);
  logic [N_STB-1:0] stbIn, lvlNow, lvlPrev;
  fifoCmd_t cmd;
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] occ;
  logic wrapped, rdActive;
  logic [DATA_W-1:0] qData;

  assign stbIn = {rtN, rdN, wrN};

  for (genvar g = 0; g < N_STB; g++) begin : g_sync
    strobe_sync u_sync (
      .clk(clk), .rstN(rstN), .strobeN(stbIn[g]),
      .lvlNow(lvlNow[g]), .lvlPrev(lvlPrev[g])
    );
  end

  sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrNow(lvlNow[0]), .wrPrev(lvlPrev[0]),
    .rdNow(lvlNow[1]), .rdPrev(lvlPrev[1]),
    .rtNow(lvlNow[2]), .rtPrev(lvlPrev[2]),
    .wrPtr(wrPtr), .wrapped(wrapped),
    .cmd(cmd), .occ(occ),
    .emptyN(emptyN), .halfN(halfN), .fullN(fullN), .rdActive(rdActive)
  );

  sfifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dIn(dIn),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .wrapped(wrapped), .qData(qData)
  );

  assign qOe  = rdActive;
  assign qOut = rdActive ? qData : '0;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        lvlNow,
  input logic [2:0]        lvlPrev,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] rdPtr,
  input logic [CNT_W-1:0]  occ,
  input logic              emptyN,
  input logic              halfN,
  input logic              fullN,
  input logic              qOe
);
  logic wrFall, rdFall, rewindReq;
  assign wrFall    = lvlPrev[0] & ~lvlNow[0];
  assign rdFall    = lvlPrev[1] & ~lvlNow[1];
  assign rewindReq = lvlPrev[2] & ~lvlNow[2] & (&lvlNow[1:0]) & (&lvlPrev[1:0]);

  // R5
  empty_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdFall && !emptyN) |=> $stable(rdPtr));
  // R5
  empty_occ_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyN |-> occ != '0);
  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrFall && !fullN) |=> $stable(wrPtr));
  // R6
  full_occ_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullN |-> occ < CNT_W'(DEPTH));
  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!fullN && !emptyN));
  // R7
  half_occ_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfN |-> occ >= CNT_W'(DEPTH / 2));
  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (!rstN)
    rewindReq |=> (rdPtr == '0) && $stable(wrPtr));
  // R10
  oe_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qOe) |-> $past(rdFall && emptyN));
endmodule

bind strobe_fifo sfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .lvlNow(lvlNow), .lvlPrev(lvlPrev),
  .wrPtr(wrPtr), .rdPtr(rdPtr), .occ(occ),
  .emptyN(emptyN), .halfN(halfN), .fullN(fullN), .qOe(qOe)
);

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
  localparam int DEPTH = 8;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RT = 2'd2, OP_RTX = 2'd3;

  // flags packed as {emptyN, halfN, fullN}
  typedef struct packed {
    logic [1:0] op;
    logic [8:0] din;
    logic [2:0] flLo;
    logic       oeLo;
    logic [8:0] qLo;
    logic [2:0] flHi;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  9'h000, 3'b011, 1'b0, 9'h000, 3'b011}, // R5 read on empty
    '{OP_WR,  9'h101, 3'b011, 1'b0, 9'h000, 3'b111}, // R4
    '{OP_WR,  9'h0F2, 3'b111, 1'b0, 9'h000, 3'b111},
    '{OP_WR,  9'h1E3, 3'b111, 1'b0, 9'h000, 3'b111},
    '{OP_WR,  9'h0D4, 3'b111, 1'b0, 9'h000, 3'b111},
    '{OP_WR,  9'h1C5, 3'b101, 1'b0, 9'h000, 3'b101}, // R7 set
    '{OP_WR,  9'h0B6, 3'b101, 1'b0, 9'h000, 3'b101},
    '{OP_WR,  9'h1A7, 3'b101, 1'b0, 9'h000, 3'b101},
    '{OP_WR,  9'h098, 3'b100, 1'b0, 9'h000, 3'b100}, // R6 set
    '{OP_WR,  9'h1FF, 3'b100, 1'b0, 9'h000, 3'b100}, // R6 ignored
    '{OP_RT,  9'h000, 3'b100, 1'b0, 9'h000, 3'b100}, // R8 wrapped
    '{OP_RD,  9'h000, 3'b100, 1'b1, 9'h101, 3'b101}, // R6 release, R3
    '{OP_RD,  9'h000, 3'b101, 1'b1, 9'h0F2, 3'b101},
    '{OP_RD,  9'h000, 3'b101, 1'b1, 9'h1E3, 3'b101},
    '{OP_RD,  9'h000, 3'b101, 1'b1, 9'h0D4, 3'b111}, // R7 release
    '{OP_WR,  9'h15A, 3'b101, 1'b0, 9'h000, 3'b101},
    '{OP_RD,  9'h000, 3'b101, 1'b1, 9'h1C5, 3'b111},
    '{OP_RD,  9'h000, 3'b111, 1'b1, 9'h0B6, 3'b111},
    '{OP_RD,  9'h000, 3'b111, 1'b1, 9'h1A7, 3'b111},
    '{OP_RD,  9'h000, 3'b111, 1'b1, 9'h098, 3'b111},
    '{OP_RD,  9'h000, 3'b011, 1'b1, 9'h15A, 3'b011}, // R5 drain
    '{OP_RD,  9'h000, 3'b011, 1'b0, 9'h000, 3'b011}, // R5 ignored
    '{OP_RT,  9'h000, 3'b111, 1'b0, 9'h000, 3'b111}, // R8 partial
    '{OP_RD,  9'h000, 3'b011, 1'b1, 9'h15A, 3'b011}, // R8 replay
    '{OP_RTX, 9'h000, 3'b011, 1'b0, 9'h000, 3'b011}, // R9
    '{OP_WR,  9'h0C3, 3'b011, 1'b0, 9'h000, 3'b111},
    '{OP_RD,  9'h000, 3'b011, 1'b1, 9'h0C3, 3'b011}  // R9 pointer kept
  };

  logic clk = 1'b0;
  logic rstN = 1'b0, wrN = 1'b1, rdN = 1'b1, rtN = 1'b1;
  logic [8:0] dIn = '0;
  logic [8:0] qOut;
  logic qOe, emptyN, halfN, fullN;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH)) i_strobe_fifo (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN), .dIn(dIn),
    .qOut(qOut), .qOe(qOe), .emptyN(emptyN), .halfN(halfN), .fullN(fullN)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  task automatic oneWord(logic wr, logic [8:0] d);
    @(negedge clk);
    if (wr) begin wrN = 1'b0; dIn = d; end else rdN = 1'b0;
    settle();
    wrN = 1'b1; rdN = 1'b1;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "flags in reset", {13'd0, emptyN, halfN, fullN}, 16'b011);
    rstN = 1'b1;
    settle();
    chk("R1", "flags after reset", {13'd0, emptyN, halfN, fullN}, 16'b011);
    chk("R1", "qOe after reset", {15'd0, qOe}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      @(negedge clk);
      case (v.op)
        OP_WR:  begin wrN = 1'b0; dIn = v.din; end
        OP_RD:  rdN = 1'b0;
        OP_RT:  rtN = 1'b0;
        default: begin rdN = 1'b0; settle(); rtN = 1'b0; end
      endcase
      settle();
      chk("R4-R9 flags", $sformatf("vec %0d low phase", i), {13'd0, emptyN, halfN, fullN}, {13'd0, v.flLo});
      chk("R10", $sformatf("vec %0d qOe", i), {15'd0, qOe}, {15'd0, v.oeLo});
      chk("R3", $sformatf("vec %0d qOut", i), {7'd0, qOut}, {7'd0, v.qLo});
      wrN = 1'b1; rdN = 1'b1; rtN = 1'b1;
      settle();
      chk("R4-R9 flags", $sformatf("vec %0d high phase", i), {13'd0, emptyN, halfN, fullN}, {13'd0, v.flHi});
      chk("R10", $sformatf("vec %0d qOe off", i), {15'd0, qOe}, 16'd0);
      chk("R10", $sformatf("vec %0d qOut off", i), {7'd0, qOut}, 16'd0);
    end

    // R2: two-edge latency on a read
    oneWord(1'b1, 9'h07E);
    @(negedge clk); rdN = 1'b0;
    @(negedge clk);
    chk("R2", "qOe after one edge", {15'd0, qOe}, 16'd0);
    @(negedge clk);
    chk("R2", "qOe after two edges", {15'd0, qOe}, 16'd1);
    chk("R2", "qOut word", {7'd0, qOut}, 16'h07E);
    rdN = 1'b1;
    settle();

    // R4: empty released only at the write's rising edge, two edges later
    @(negedge clk); wrN = 1'b0; dIn = 9'h111;
    settle();
    chk("R4", "emptyN with write low", {15'd0, emptyN}, 16'd0);
    wrN = 1'b1;
    @(negedge clk);
    chk("R2", "emptyN one edge after rise", {15'd0, emptyN}, 16'd0);
    @(negedge clk);
    chk("R4", "emptyN after rise", {15'd0, emptyN}, 16'd1);

    // R1: reset in mid-stream
    oneWord(1'b1, 9'h122);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1", "flags in mid-run reset", {13'd0, emptyN, halfN, fullN}, 16'b011);
    rstN = 1'b1;
    oneWord(1'b1, 9'h0AA);
    oneWord(1'b1, 9'h155);
    @(negedge clk); rdN = 1'b0;
    settle();
    chk("R1", "first word after reset", {7'd0, qOut}, 16'h0AA);
    rdN = 1'b1;
    settle();
    @(negedge clk); rdN = 1'b0;
    settle();
    chk("R3", "second word after reset", {7'd0, qOut}, 16'h155);
    rdN = 1'b1;
    settle();
    chk("R5", "drained after reset", {13'd0, emptyN, halfN, fullN}, 16'b011);

    finishRun();
  end
endmodule